// File: doc/BRIEF.md
# Advanced load address table

This block tracks loads that a compiler has hoisted above possibly conflicting stores. When an advanced load issues, the table records which destination register it wrote, the address it read and how many bytes it read. Every store that executes is snooped against all recorded loads at once. Any entry whose byte range intersects the store's byte range is dropped, which silently marks that load's speculation as broken.

When the program reaches the point where the hoisted value is consumed, a check names the destination register. If a live entry for that register remains, the speculative value is good and nothing happens. If not, the block raises a fix-up request so that recovery code can redo the load in program order.

The table holds 32 entries by default and is fully associative. A register is never held twice. A new load fills the lowest free slot. When the table is full, it replaces entries in round-robin order.

Top module: `alat_table`

## Requirements
- R1: After reset no entry is valid, so a check of any register raises fixup and not hit.
- R2: An allocate of register r makes a check of r, from the next cycle on, report hit=1 and fixup=0.
- R3: A check of a register with no valid entry reports hit=0 and fixup=1. When the check-valid input is low, both hit and fixup are 0.
- R4: A store invalidates an entry when the byte ranges [addr, addr+size) intersect. The size code maps 0 to 1 byte, 1 to 2 bytes, 2 to 4 bytes and 3 to 8 bytes.
- R5: A store whose byte range only abuts an entry's range, on either side, leaves that entry valid.
- R6: In one cycle a store invalidates every overlapping entry and leaves all other entries untouched.
- R7: An allocate of a register that is already present overwrites that entry's address and size. It does not take a second slot.
- R8: An allocate of a new register takes the lowest-numbered free slot, so NUM_ENTRIES distinct registers can be held at once.
- R9: When the table is full, an allocate of a new register replaces slots in round-robin order starting at slot 0. The pointer advances only on such a replacement.
- R10: When a store and an allocate occur in the same cycle, the store is applied first, so the new entry survives even if it overlaps the store.
- R11: A check is answered combinationally from the current contents and removes nothing. A cycle with no allocate and no store leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Advanced load allocates an entry |
| alloc_reg_i | input | REG_W | Destination register of the advanced load |
| alloc_addr_i | input | ADDR_W | Load byte address |
| alloc_size_i | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| store_valid_i | input | 1 | Store snoop valid |
| store_addr_i | input | ADDR_W | Store byte address |
| store_size_i | input | 2 | Store size code |
| chk_valid_i | input | 1 | Advanced-load check valid |
| chk_reg_i | input | REG_W | Register named by the check |
| chk_hit_o | output | 1 | Entry for the checked register still present |
| chk_fixup_o | output | 1 | Entry absent: branch to fix-up code |

## Verification
The assertions assume that every input is at a known value on each clock edge after reset is released. They also assume that addresses are plain byte addresses, and the comparison carries one extra bit so that a range never wraps past the top of the address space. The stimulus changes inputs only on the falling edge and keeps every control input driven at all times. It uses addresses well below the top of the address space and only the four legal size codes. A reference model built from the requirements predicts the check outputs on every cycle. This covers directed cases for abutting and overlapping ranges, overwrites and round-robin eviction, followed by a long random mix of allocates, stores and checks over a small set of registers and addresses.

// File: rtl/alat_pkg.sv
package alat_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  function automatic logic [3:0] size_bytes(acc_size_e s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/alat_overlap.sv
module alat_overlap
  import alat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic [NUM_ENTRIES-1:0]             valid_i,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_addr_i,
  input  logic [NUM_ENTRIES-1:0][1:0]        ent_size_i,
  input  logic                               snoop_valid_i,
  input  logic [ADDR_W-1:0]                  snoop_addr_i,
  input  logic [1:0]                         snoop_size_i,
  output logic [NUM_ENTRIES-1:0]             kill_o
);
  // one extra bit keeps range ends from wrapping
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] s_lo, s_hi;
  assign s_lo = {1'b0, snoop_addr_i};
  assign s_hi = s_lo + EXT_W'(size_bytes(acc_size_e'(snoop_size_i)));

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [EXT_W-1:0] e_lo, e_hi;
    assign e_lo = {1'b0, ent_addr_i[g]};
    assign e_hi = e_lo + EXT_W'(size_bytes(acc_size_e'(ent_size_i[g])));
    assign kill_o[g] = snoop_valid_i & valid_i[g] & (e_lo < s_hi) & (s_lo < e_hi);
  end
endmodule

// File: rtl/alat_lookup.sv
module alat_lookup #(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned REG_W       = 7,
  parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0]            valid_i,
  input  logic [NUM_ENTRIES-1:0][REG_W-1:0] ent_reg_i,
  input  logic [REG_W-1:0]                  key_i,
  output logic [NUM_ENTRIES-1:0]            match_o,
  output logic                              hit_o,
  output logic [IDX_W-1:0]                  idx_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    assign match_o[g] = valid_i[g] & (ent_reg_i[g] == key_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/alat_victim.sv
module alat_victim #(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  logic                   alloc_i,
  input  logic                   reg_hit_i,
  input  logic [IDX_W-1:0]       reg_idx_i,
  output logic [IDX_W-1:0]       slot_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;
  logic             replace;

  // lowest free slot wins
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign replace = alloc_i & ~reg_hit_i & ~free_any;
  assign slot_o  = reg_hit_i ? reg_idx_i : (free_any ? free_idx : rr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (replace) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  p_rr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && !reg_hit_i && (&valid_i)) |=> $stable(rr_q));

  p_free_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !reg_hit_i && !(&valid_i)) |-> !valid_i[slot_o]);
endmodule

// File: rtl/alat_table.sv
module alat_table
  import alat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned REG_W       = 7,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [REG_W-1:0]  alloc_reg_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [1:0]        alloc_size_i,
  input  logic              store_valid_i,
  input  logic [ADDR_W-1:0] store_addr_i,
  input  logic [1:0]        store_size_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  output logic              chk_hit_o,
  output logic              chk_fixup_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0]             valid_q;
  logic [NUM_ENTRIES-1:0][REG_W-1:0]  reg_q;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_ENTRIES-1:0][1:0]        size_q;

  logic [NUM_ENTRIES-1:0] kill;
  logic [NUM_ENTRIES-1:0] alloc_match;
  logic                   alloc_hit;
  logic [IDX_W-1:0]       alloc_idx;
  logic [IDX_W-1:0]       slot;
  logic [NUM_ENTRIES-1:0] chk_match;
  logic                   chk_any;
  logic [IDX_W-1:0]       chk_idx;

  alat_overlap #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_overlap (
    .valid_i      (valid_q),
    .ent_addr_i   (addr_q),
    .ent_size_i   (size_q),
    .snoop_valid_i(store_valid_i),
    .snoop_addr_i (store_addr_i),
    .snoop_size_i (store_size_i),
    .kill_o       (kill)
  );

  alat_lookup #(.NUM_ENTRIES(NUM_ENTRIES), .REG_W(REG_W), .IDX_W(IDX_W)) u_alloc_lkp (
    .valid_i  (valid_q),
    .ent_reg_i(reg_q),
    .key_i    (alloc_reg_i),
    .match_o  (alloc_match),
    .hit_o    (alloc_hit),
    .idx_o    (alloc_idx)
  );

  alat_lookup #(.NUM_ENTRIES(NUM_ENTRIES), .REG_W(REG_W), .IDX_W(IDX_W)) u_chk_lkp (
    .valid_i  (valid_q),
    .ent_reg_i(reg_q),
    .key_i    (chk_reg_i),
    .match_o  (chk_match),
    .hit_o    (chk_any),
    .idx_o    (chk_idx)
  );

  alat_victim #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .alloc_i  (alloc_valid_i),
    .reg_hit_i(alloc_hit),
    .reg_idx_i(alloc_idx),
    .slot_o   (slot)
  );

  assign chk_hit_o   = chk_valid_i & chk_any;
  assign chk_fixup_o = chk_valid_i & ~chk_any;

  // store kills first, allocate write lands last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      reg_q   <= '0;
      addr_q  <= '0;
      size_q  <= '0;
    end else begin
      valid_q <= valid_q & ~kill;
      if (alloc_valid_i) begin
        valid_q[slot] <= 1'b1;
        reg_q[slot]   <= alloc_reg_i;
        addr_q[slot]  <= alloc_addr_i;
        size_q[slot]  <= alloc_size_i;
      end
    end
  end

  function automatic logic reg_present(logic [REG_W-1:0] r);
    logic f = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) if (valid_q[i] && reg_q[i] == r) f = 1'b1;
    return f;
  endfunction

  function automatic logic any_overlap(logic [ADDR_W-1:0] a, logic [1:0] sz);
    logic f = 1'b0;
    longint lo, hi, elo, ehi;
    lo = longint'(a);
    hi = lo + (longint'(1) << sz);
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      elo = longint'(addr_q[i]);
      ehi = elo + (longint'(1) << size_q[i]);
      if (valid_q[i] && elo < hi && lo < ehi) f = 1'b1;
    end
    return f;
  endfunction

  p_alloc_present_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i |=> reg_present($past(alloc_reg_i)));

  p_store_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_valid_i && !alloc_valid_i) |=> !any_overlap($past(store_addr_i), $past(store_size_i)));

  p_unique_reg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chk_match));

  p_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!store_valid_i && !alloc_valid_i) |=> $stable(valid_q));
endmodule

// File: tb/tb_alat_table.sv
module tb_alat_table;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [6:0]  alloc_reg = '0;
  logic [31:0] alloc_addr = '0;
  logic [1:0]  alloc_size = '0;
  logic        store_valid = 1'b0;
  logic [31:0] store_addr = '0;
  logic [1:0]  store_size = '0;
  logic        chk_valid = 1'b0;
  logic [6:0]  chk_reg = '0;
  logic        chk_hit, chk_fixup;

  always #(CLK_PERIOD/2) clk = ~clk;

  alat_table dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_reg_i(alloc_reg),
    .alloc_addr_i(alloc_addr), .alloc_size_i(alloc_size),
    .store_valid_i(store_valid), .store_addr_i(store_addr), .store_size_i(store_size),
    .chk_valid_i(chk_valid), .chk_reg_i(chk_reg),
    .chk_hit_o(chk_hit), .chk_fixup_o(chk_fixup)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model
  bit     m_val[N];
  int     m_reg[N];
  longint m_lo[N];
  longint m_hi[N];
  int     m_ptr;

  function automatic void model_clear();
    for (int i = 0; i < N; i++) m_val[i] = 0;
    m_ptr = 0;
  endfunction

  function automatic bit model_has(int r);
    for (int i = 0; i < N; i++) if (m_val[i] && m_reg[i] == r) return 1;
    return 0;
  endfunction

  function automatic void model_step(bit av, int ar, longint aa, int asz,
                                     bit sv, longint sa, int ssz);
    int tgt = -1;
    longint slo = sa, shi = sa + (longint'(1) << ssz);
    if (av) begin
      for (int i = 0; i < N; i++) if (m_val[i] && m_reg[i] == ar) tgt = i;
      if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!m_val[i]) tgt = i;
      if (tgt < 0) begin
        tgt = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    if (sv) for (int i = 0; i < N; i++)
      if (m_val[i] && m_lo[i] < shi && slo < m_hi[i]) m_val[i] = 0;
    if (av) begin
      m_val[tgt] = 1;
      m_reg[tgt] = ar;
      m_lo[tgt]  = aa;
      m_hi[tgt]  = aa + (longint'(1) << asz);
    end
  endfunction

  task automatic cyc(input bit av, input int ar, input longint aa, input int asz,
                     input bit sv, input longint sa, input int ssz,
                     input bit cv, input int cr, input string tag);
    bit exp_hit;
    @(negedge clk);
    alloc_valid = av; alloc_reg = 7'(ar); alloc_addr = 32'(aa); alloc_size = 2'(asz);
    store_valid = sv; store_addr = 32'(sa); store_size = 2'(ssz);
    chk_valid = cv; chk_reg = 7'(cr);
    #1;
    exp_hit = cv && model_has(cr);
    n_tests++;
    if (chk_hit !== exp_hit || chk_fixup !== (cv && !exp_hit)) begin
      n_fail++;
      $display("FAIL %s reg=%0d hit/fixup=%b%b expected %b%b", tag, cr,
               chk_hit, chk_fixup, exp_hit, cv && !exp_hit);
    end
    model_step(av, ar, aa, asz, sv, sa, ssz);
  endtask

  task automatic alloc(input int r, input longint a, input int sz, input string tag);
    cyc(1, r, a, sz, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic store(input longint a, input int sz, input string tag);
    cyc(0, 0, 0, 0, 1, a, sz, 0, 0, tag);
  endtask
  task automatic check(input int r, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, r, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    alloc_valid = 0; store_valid = 0; chk_valid = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;

    for (int r = 0; r < 4; r++) check(r, "R1");

    alloc(5, 'h100, 3, "R2");
    check(5, "R2");
    check(6, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 5, "R3");   // check-valid low
    check(5, "R11");
    check(5, "R11");

    store('h108, 2, "R5");
    check(5, "R5");
    store('h0FF, 0, "R5");
    check(5, "R5");
    store('h107, 1, "R4");
    check(5, "R4");

    alloc(1, 'h200, 2, "R6");
    alloc(2, 'h204, 2, "R6");
    alloc(3, 'h300, 0, "R6");
    store('h202, 2, "R6");
    check(1, "R6");
    check(2, "R6");
    check(3, "R6");

    alloc(9, 'h400, 3, "R7");
    alloc(9, 'h500, 3, "R7");
    store('h400, 3, "R7");
    check(9, "R7");
    store('h504, 0, "R7");
    check(9, "R7");

    cyc(1, 10, 'h600, 3, 1, 'h600, 3, 0, 0, "R10");
    check(10, "R10");

    do_reset();
    check(20, "R1");
    for (int r = 20; r < 20 + N; r++) alloc(r, 'h1000 + r * 16, 2, "R8");
    for (int r = 20; r < 20 + N; r++) check(r, "R8");
    alloc(30, 'h9000, 3, "R7");              // present reg, no eviction
    check(20, "R7");
    alloc(60, 'h2000, 2, "R9");
    check(20, "R9");
    check(21, "R9");
    check(60, "R9");
    alloc(61, 'h2010, 2, "R9");
    check(21, "R9");
    check(22, "R9");

    do_reset();
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 3) == 0, $urandom % 16, 'h40 + ($urandom % 64), $urandom % 4,
          ($urandom % 4) == 0, 'h40 + ($urandom % 64), $urandom % 4,
          ($urandom % 4) != 0, $urandom % 16, "R11");
    end

    @(negedge clk);
    alloc_valid = 0; store_valid = 0; chk_valid = 0;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule